// File: doc/BRIEF.md
# Configurable Partial-Bypass Operand Forwarding Unit

This block sits at the operand-read stage of a single-issue, in-order pipeline with three execution pipes: integer, multiply and memory. Each pipe has three stages: a first execute stage, a second execute stage and a writeback stage. For each of two source operands, the block compares the operand's register tag against the destination tags of all nine in-flight stages. It then does one of three things: forwards a result over a bypass path, passes the register-file value through, or asserts a stall.

Seven of the nine stages can drive a bypass path. Each operand has its own 7-bit configuration mask that enables or removes each of those paths. The interlock therefore stalls exactly when the value an operand needs is reachable only over a path that the mask has removed. A stall holds the operand-read stage and everything before it. The block also owns the register into the first execute stage, and during a stall that register is loaded with a bubble.

Top module: `opnd_fwd_unit`

## Requirements
- R1: Each operand has its own 7-bit mask, in this bit order: bit0 integer stage 1, bit1 integer stage 2, bit2 integer writeback, bit3 multiply stage 2, bit4 multiply writeback, bit5 memory stage 2, bit6 memory writeback. Multiply stage 1 and memory stage 1 never forward. Flat stage index s = pipe*3 + depth, where pipe 0 is integer, 1 is multiply and 2 is memory, and depth runs 0 to 2.
- R2: A stage can supply an operand only when four conditions hold: its valid bit is set, its tag equals the operand tag, its ready bit is set, and its mask bit is set. The supplied data appears on the execute-stage operand output after the next clock edge.
- R3: When several valid stages match the same operand tag, only the youngest counts. The youngest is the one with the smallest depth; at equal depth the integer pipe comes before multiply, and multiply before memory. If that youngest match cannot forward, the block stalls and never uses an older copy.
- R4: An operand with no matching valid stage takes the register-file input and causes no stall.
- R5: A used operand whose youngest match cannot forward asserts the stall. As a producer moves down its pipe, the number of stall cycles equals the number of stages it moves before it reaches an enabled stage. If it never reaches one, the count equals the number of stages it moves until it retires into the register file after writeback.
- R6: An issue request while the execution resource is busy stalls, even with no data hazard.
- R7: An operand whose use bit is clear never causes a stall.
- R8: A stalled cycle loads a bubble: the execute valid output is 0 after the edge, and both execute operand outputs keep their values. An issue with no stall sets the execute valid output to 1 after the edge.
- R9: While reset is held low, the execute valid output and both execute operand outputs are 0.
- R10: With the default parameter ZERO_REG_FIXED = 0, register tag 0 matches and interlocks like any other tag.
- R11: The stall output is 0 whenever no issue request is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mask_a_i | input | 7 | Bypass enable mask for operand A |
| cfg_mask_b_i | input | 7 | Bypass enable mask for operand B |
| src_use_i | input | 2 | Operand used: bit0 A, bit1 B |
| src_tag_a_i | input | TAG_W | Register tag of operand A |
| src_tag_b_i | input | TAG_W | Register tag of operand B |
| rf_data_a_i | input | DATA_W | Register-file read value for operand A |
| rf_data_b_i | input | DATA_W | Register-file read value for operand B |
| issue_vld_i | input | 1 | Instruction present in operand read |
| pipe_busy_i | input | 1 | Target execution resource occupied |
| stg_vld_i | input | 9 | Valid per in-flight stage (index s) |
| stg_rdy_i | input | 9 | Result computed by stage s |
| stg_tag_i | input | 9*TAG_W | Destination tag per stage, stage s at bits s*TAG_W |
| stg_data_i | input | 9*DATA_W | Result data per stage, stage s at bits s*DATA_W |
| stall_o | output | 1 | Hold operand read and earlier stages |
| ex_vld_o | output | 1 | First execute stage holds a valid operation |
| ex_opnd_a_o | output | DATA_W | Operand A latched for execute |
| ex_opnd_b_o | output | DATA_W | Operand B latched for execute |

## Verification
The assertions check four per-cycle rules: the stall never appears without an issue request, a busy resource always stalls, each stall turns into a bubble with held operands, and a cycle with no valid producer never stalls. They also check forwarding from the youngest integer stage on both operands. Only the bench's scenarios can show three further behaviours. The first is the stall-cycle count as a producer advances from each starting distance in each pipe under all 128 masks for each operand. The second is youngest-match priority that blocks an older enabled copy. The third is that the two operands' masks are independent of each other.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int NUM_PIPES  = 3;
  localparam int PIPE_DEPTH = 3;
  localparam int NUM_STG    = NUM_PIPES * PIPE_DEPTH;
  localparam int MASK_W     = 7;
  localparam int NUM_OPND   = 2;

  typedef struct packed {
    logic hit;  // valid producer of this tag
    logic fwd;  // hit that can be delivered this cycle
  } match_t;

  function automatic int stg_idx(int pipe, int depth);
    return pipe * PIPE_DEPTH + depth;
  endfunction

  // mask bit of a stage, -1 when the stage has no bypass path
  function automatic int mask_bit(int pipe, int depth);
    if (pipe != 0 && depth == 0) return -1;
    return 2 * pipe + depth;
  endfunction
endpackage

// File: rtl/fwd_stage_match.sv
module fwd_stage_match
  import fwd_pkg::*;
#(
  parameter int TAG_W          = 5,
  parameter bit ZERO_REG_FIXED = 1'b0
) (
  input  logic [TAG_W-1:0] opnd_tag_i,
  input  logic             path_en_i,
  input  logic             vld_i,
  input  logic             rdy_i,
  input  logic [TAG_W-1:0] tag_i,
  output match_t           res_o
);
  logic zero_skip;
  assign zero_skip = ZERO_REG_FIXED && (opnd_tag_i == '0);
  assign res_o.hit = vld_i && (tag_i == opnd_tag_i) && !zero_skip;
  assign res_o.fwd = res_o.hit && rdy_i && path_en_i;
endmodule

// File: rtl/fwd_operand_sel.sv
module fwd_operand_sel
  import fwd_pkg::*;
#(
  parameter int TAG_W          = 5,
  parameter int DATA_W         = 32,
  parameter bit ZERO_REG_FIXED = 1'b0
) (
  input  logic                      use_i,
  input  logic [TAG_W-1:0]          tag_i,
  input  logic [MASK_W-1:0]         mask_i,
  input  logic [DATA_W-1:0]         rf_data_i,
  input  logic [NUM_STG-1:0]        stg_vld_i,
  input  logic [NUM_STG-1:0]        stg_rdy_i,
  input  logic [NUM_STG*TAG_W-1:0]  stg_tag_i,
  input  logic [NUM_STG*DATA_W-1:0] stg_data_i,
  output logic [DATA_W-1:0]         data_o,
  output logic                      hazard_o
);
  match_t             res [NUM_STG];
  logic [NUM_STG-1:0] path_en;

  for (genvar p = 0; p < NUM_PIPES; p++) begin : g_pipe
    for (genvar d = 0; d < PIPE_DEPTH; d++) begin : g_dep
      localparam int S  = stg_idx(p, d);
      localparam int MB = mask_bit(p, d);
      if (MB >= 0) begin : g_path
        assign path_en[S] = mask_i[MB];
      end else begin : g_nopath
        assign path_en[S] = 1'b0;
      end
      fwd_stage_match #(
        .TAG_W          (TAG_W),
        .ZERO_REG_FIXED (ZERO_REG_FIXED)
      ) u_match (
        .opnd_tag_i (tag_i),
        .path_en_i  (path_en[S]),
        .vld_i      (stg_vld_i[S]),
        .rdy_i      (stg_rdy_i[S]),
        .tag_i      (stg_tag_i[S*TAG_W +: TAG_W]),
        .res_o      (res[S])
      );
    end
  end

  // youngest first: scan by depth, then pipe
  logic              found;
  logic              sel_fwd;
  logic [DATA_W-1:0] sel_data;
  always_comb begin
    found    = 1'b0;
    sel_fwd  = 1'b0;
    sel_data = rf_data_i;
    for (int d = 0; d < PIPE_DEPTH; d++) begin
      for (int p = 0; p < NUM_PIPES; p++) begin
        if (!found && res[p*PIPE_DEPTH+d].hit) begin
          found    = 1'b1;
          sel_fwd  = res[p*PIPE_DEPTH+d].fwd;
          sel_data = stg_data_i[(p*PIPE_DEPTH+d)*DATA_W +: DATA_W];
        end
      end
    end
  end

  assign data_o   = sel_data;
  assign hazard_o = use_i && found && !sel_fwd;
endmodule

// File: rtl/fwd_ex_reg.sv
module fwd_ex_reg #(
  parameter int DATA_W = 32,
  parameter int N_OPND = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     load_i,
  input  logic [N_OPND*DATA_W-1:0] opnd_i,
  output logic                     vld_o,
  output logic [N_OPND*DATA_W-1:0] opnd_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      opnd_o <= '0;
    end else begin
      vld_o <= load_i;  // bubble when not loaded
      if (load_i) opnd_o <= opnd_i;
    end
  end
endmodule

// File: rtl/opnd_fwd_unit.sv
module opnd_fwd_unit
  import fwd_pkg::*;
#(
  parameter int TAG_W          = 5,
  parameter int DATA_W         = 32,
  parameter bit ZERO_REG_FIXED = 1'b0
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [MASK_W-1:0]         cfg_mask_a_i,
  input  logic [MASK_W-1:0]         cfg_mask_b_i,
  input  logic [NUM_OPND-1:0]       src_use_i,
  input  logic [TAG_W-1:0]          src_tag_a_i,
  input  logic [TAG_W-1:0]          src_tag_b_i,
  input  logic [DATA_W-1:0]         rf_data_a_i,
  input  logic [DATA_W-1:0]         rf_data_b_i,
  input  logic                      issue_vld_i,
  input  logic                      pipe_busy_i,
  input  logic [NUM_STG-1:0]        stg_vld_i,
  input  logic [NUM_STG-1:0]        stg_rdy_i,
  input  logic [NUM_STG*TAG_W-1:0]  stg_tag_i,
  input  logic [NUM_STG*DATA_W-1:0] stg_data_i,
  output logic                      stall_o,
  output logic                      ex_vld_o,
  output logic [DATA_W-1:0]         ex_opnd_a_o,
  output logic [DATA_W-1:0]         ex_opnd_b_o
);
  logic [NUM_OPND-1:0][MASK_W-1:0] mask_v;
  logic [NUM_OPND-1:0][TAG_W-1:0]  tag_v;
  logic [NUM_OPND-1:0][DATA_W-1:0] rf_v;
  logic [NUM_OPND-1:0][DATA_W-1:0] sel_v;
  logic [NUM_OPND-1:0]             haz_v;
  logic [NUM_OPND*DATA_W-1:0]      ex_q;
  logic                            load;

  assign mask_v = {cfg_mask_b_i, cfg_mask_a_i};
  assign tag_v  = {src_tag_b_i, src_tag_a_i};
  assign rf_v   = {rf_data_b_i, rf_data_a_i};

  for (genvar o = 0; o < NUM_OPND; o++) begin : g_opnd
    fwd_operand_sel #(
      .TAG_W          (TAG_W),
      .DATA_W         (DATA_W),
      .ZERO_REG_FIXED (ZERO_REG_FIXED)
    ) u_sel (
      .use_i      (src_use_i[o]),
      .tag_i      (tag_v[o]),
      .mask_i     (mask_v[o]),
      .rf_data_i  (rf_v[o]),
      .stg_vld_i  (stg_vld_i),
      .stg_rdy_i  (stg_rdy_i),
      .stg_tag_i  (stg_tag_i),
      .stg_data_i (stg_data_i),
      .data_o     (sel_v[o]),
      .hazard_o   (haz_v[o])
    );
  end

  assign stall_o = issue_vld_i && ((|haz_v) || pipe_busy_i);
  assign load    = issue_vld_i && !stall_o;

  fwd_ex_reg #(
    .DATA_W (DATA_W),
    .N_OPND (NUM_OPND)
  ) u_ex (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .opnd_i (sel_v),
    .vld_o  (ex_vld_o),
    .opnd_o (ex_q)
  );

  assign ex_opnd_a_o = ex_q[DATA_W-1:0];
  assign ex_opnd_b_o = ex_q[2*DATA_W-1:DATA_W];
endmodule

// File: rtl/opnd_fwd_unit_chk.sv
module opnd_fwd_unit_chk #(
  parameter int TAG_W          = 5,
  parameter int DATA_W         = 32,
  parameter bit ZERO_REG_FIXED = 1'b0,
  parameter int N_STG          = 9
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              issue_vld_i,
  input logic              pipe_busy_i,
  input logic              stall_o,
  input logic              ex_vld_o,
  input logic [DATA_W-1:0] ex_opnd_a_o,
  input logic [DATA_W-1:0] ex_opnd_b_o,
  input logic [N_STG-1:0]  stg_vld_i,
  input logic [1:0]        use_i,
  input logic              mask_a0_i,
  input logic              mask_b0_i,
  input logic [TAG_W-1:0]  tag_a_i,
  input logic [TAG_W-1:0]  tag_b_i,
  input logic              x1_rdy_i,
  input logic [TAG_W-1:0]  x1_tag_i,
  input logic [DATA_W-1:0] x1_data_i
);
  // R11
  stall_needs_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> issue_vld_i);

  // R6
  busy_stalls_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_vld_i && pipe_busy_i |-> stall_o);

  // R8
  bubble_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !ex_vld_o);

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(ex_opnd_a_o) && $stable(ex_opnd_b_o));

  // R8
  issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_vld_i && !stall_o |=> ex_vld_o);

  // R4
  no_producer_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_vld_i && !pipe_busy_i && stg_vld_i == '0 |-> !stall_o);

  // R2
  x1_fwd_a_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_vld_i && !stall_o && use_i[0] && stg_vld_i[0] && x1_rdy_i && mask_a0_i &&
    x1_tag_i == tag_a_i && (!ZERO_REG_FIXED || tag_a_i != '0)
    |=> ex_opnd_a_o == $past(x1_data_i));

  // R2
  x1_fwd_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_vld_i && !stall_o && use_i[1] && stg_vld_i[0] && x1_rdy_i && mask_b0_i &&
    x1_tag_i == tag_b_i && (!ZERO_REG_FIXED || tag_b_i != '0)
    |=> ex_opnd_b_o == $past(x1_data_i));
endmodule

bind opnd_fwd_unit opnd_fwd_unit_chk #(
  .TAG_W          (TAG_W),
  .DATA_W         (DATA_W),
  .ZERO_REG_FIXED (ZERO_REG_FIXED),
  .N_STG          (fwd_pkg::NUM_STG)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .issue_vld_i (issue_vld_i),
  .pipe_busy_i (pipe_busy_i),
  .stall_o     (stall_o),
  .ex_vld_o    (ex_vld_o),
  .ex_opnd_a_o (ex_opnd_a_o),
  .ex_opnd_b_o (ex_opnd_b_o),
  .stg_vld_i   (stg_vld_i),
  .use_i       (src_use_i),
  .mask_a0_i   (cfg_mask_a_i[0]),
  .mask_b0_i   (cfg_mask_b_i[0]),
  .tag_a_i     (src_tag_a_i),
  .tag_b_i     (src_tag_b_i),
  .x1_rdy_i    (stg_rdy_i[0]),
  .x1_tag_i    (stg_tag_i[TAG_W-1:0]),
  .x1_data_i   (stg_data_i[DATA_W-1:0])
);

// File: tb/opnd_fwd_unit_test.sv
module opnd_fwd_unit_test;
  localparam int TAG_W  = 5;
  localparam int DATA_W = 32;
  localparam int NS     = 9;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_ni;
  logic [6:0]        mask_a, mask_b;
  logic [1:0]        use_v;
  logic [TAG_W-1:0]  tag_a, tag_b;
  logic [DATA_W-1:0] rf_a, rf_b;
  logic              issue, busy;
  logic [NS-1:0]     vld, rdy;
  logic [TAG_W-1:0]  tg [NS];
  logic [DATA_W-1:0] dt [NS];
  logic [NS*TAG_W-1:0]  tg_flat;
  logic [NS*DATA_W-1:0] dt_flat;
  logic              stall, ex_vld;
  logic [DATA_W-1:0] ex_a, ex_b;

  always_comb begin
    for (int s = 0; s < NS; s++) begin
      tg_flat[s*TAG_W +: TAG_W]   = tg[s];
      dt_flat[s*DATA_W +: DATA_W] = dt[s];
    end
  end

  opnd_fwd_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_mask_a_i(mask_a), .cfg_mask_b_i(mask_b),
    .src_use_i(use_v), .src_tag_a_i(tag_a), .src_tag_b_i(tag_b),
    .rf_data_a_i(rf_a), .rf_data_b_i(rf_b),
    .issue_vld_i(issue), .pipe_busy_i(busy),
    .stg_vld_i(vld), .stg_rdy_i(rdy), .stg_tag_i(tg_flat), .stg_data_i(dt_flat),
    .stall_o(stall), .ex_vld_o(ex_vld), .ex_opnd_a_o(ex_a), .ex_opnd_b_o(ex_b)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear();
    vld = '0; rdy = '1; busy = 0; issue = 0; use_v = 2'b00;
    mask_a = '1; mask_b = '1; tag_a = '0; tag_b = '0; rf_a = '0; rf_b = '0;
    for (int s = 0; s < NS; s++) begin tg[s] = '0; dt[s] = '0; end
  endtask

  task automatic put(int s, logic [TAG_W-1:0] t, logic [DATA_W-1:0] v);
    vld[s] = 1'b1; tg[s] = t; dt[s] = v;
  endtask

  // inputs already driven after a negedge
  task automatic step(string req, bit exp_stall, bit exp_vld, bit chk_a, logic [DATA_W-1:0] exp_a);
    #1 chk({req, " stall"}, stall, exp_stall);
    @(posedge clk); #1;
    chk({req, " ex_vld"}, ex_vld, exp_vld);
    if (chk_a) chk({req, " ex_a"}, ex_a, exp_a);
  endtask

  // producer walks down pipe p from depth d0; count stalls until operand o resolves
  task automatic run_seq(int p, int d0, int o, logic [6:0] m);
    logic [DATA_W-1:0] val;
    int d, cnt, exp_cnt;
    val = 32'hC000_0000 + (32'(m) << 16) + (32'(p) << 8) + (32'(d0) << 4) + 32'(o);
    @(negedge clk);
    clear();
    issue = 1; use_v = (o == 0) ? 2'b01 : 2'b10;
    mask_a = (o == 0) ? m : ~m;
    mask_b = (o == 0) ? ~m : m;
    tag_a = 5'd9; tag_b = 5'd9;
    rf_a = 32'h5EED_0000; rf_b = 32'h5EED_0000;
    d = d0;
    put(p*3 + d, 5'd9, val);
    exp_cnt = 3 - d0;
    for (int dd = d0; dd < 3; dd++) begin
      if ((p == 0 || dd > 0) && m[2*p + dd]) begin exp_cnt = dd - d0; break; end
    end
    cnt = 0;
    for (int g = 0; g < 6; g++) begin
      #1;
      if (!stall) break;
      cnt++;
      @(negedge clk);
      vld[p*3 + d] = 1'b0;
      if (d == 2) begin rf_a = val; rf_b = val; end
      else begin d++; put(p*3 + d, 5'd9, val); end
    end
    @(posedge clk); #1;
    chk($sformatf("R5 stall count pipe%0d dist%0d op%0d mask%0d", p, d0, o, m), 64'(cnt), 64'(exp_cnt));
    chk($sformatf("R2 R1 data pipe%0d dist%0d op%0d mask%0d", p, d0, o, m),
        (o == 0) ? ex_a : ex_b, val);
  endtask

  initial begin
    rst_ni = 1'b0;
    clear();
    repeat (2) @(posedge clk);
    #1;
    chk("R9 ex_vld in reset", ex_vld, 0);
    chk("R9 ex_a in reset", ex_a, 0);
    chk("R9 ex_b in reset", ex_b, 0);
    @(negedge clk) rst_ni = 1'b1;

    // R4 tag mismatch uses register file
    @(negedge clk); clear(); issue = 1; use_v = 2'b01; tag_a = 5'd3; rf_a = 32'h1111;
    put(0, 5'd4, 32'hDEAD);
    step("R4 mismatch", 0, 1, 1, 32'h1111);

    // R3 youngest of two enabled copies
    @(negedge clk); clear(); issue = 1; use_v = 2'b01; tag_a = 5'd6;
    put(0, 5'd6, 32'hAAAA); put(2, 5'd6, 32'hBBBB);
    step("R3 youngest wins", 0, 1, 1, 32'hAAAA);

    // R3 youngest path removed: no fallback to older enabled copy
    @(negedge clk); clear(); issue = 1; use_v = 2'b01; tag_a = 5'd6; mask_a = 7'b1111110;
    put(0, 5'd6, 32'hAAAA); put(2, 5'd6, 32'hBBBB);
    step("R3 no fallback", 1, 0, 0, 0);

    // R3 multiply stage 1 is younger than integer writeback
    @(negedge clk); clear(); issue = 1; use_v = 2'b01; tag_a = 5'd6;
    put(3, 5'd6, 32'hAAAA); put(2, 5'd6, 32'hBBBB);
    step("R3 M1 younger", 1, 0, 0, 0);

    // R2 ready low stalls, then forwards
    @(negedge clk); clear(); issue = 1; use_v = 2'b01; tag_a = 5'd6;
    put(1, 5'd6, 32'h7777); rdy[1] = 1'b0;
    step("R2 not ready", 1, 0, 0, 0);
    @(negedge clk); rdy[1] = 1'b1;
    step("R2 ready", 0, 1, 1, 32'h7777);

    // R1 per-operand masks
    @(negedge clk); clear(); issue = 1; use_v = 2'b11; tag_a = 5'd6; tag_b = 5'd6;
    mask_b = 7'b0; put(2, 5'd6, 32'h4444);
    step("R1 operand B masked", 1, 0, 0, 0);
    @(negedge clk); use_v = 2'b01;
    step("R1 operand A independent", 0, 1, 1, 32'h4444);

    // R1 bit order: multiply writeback is bit4, not bit3
    @(negedge clk); clear(); issue = 1; use_v = 2'b01; tag_a = 5'd2; mask_a = 7'b0010000;
    put(5, 5'd2, 32'h5555);
    step("R1 MWB bit4", 0, 1, 1, 32'h5555);
    @(negedge clk); mask_a = 7'b0001000;
    step("R1 MWB not bit3", 1, 0, 0, 0);

    // R8 bubble holds operands; R6 busy stalls
    @(negedge clk); clear(); issue = 1; use_v = 2'b01; tag_a = 5'd1; rf_a = 32'h2222;
    step("R8 clean issue", 0, 1, 1, 32'h2222);
    @(negedge clk); busy = 1; rf_a = 32'h3333;
    step("R6 busy", 1, 0, 0, 0);
    chk("R8 hold operand", ex_a, 32'h2222);

    // R7 unused operand with hazard
    @(negedge clk); clear(); issue = 1; use_v = 2'b00; tag_a = 5'd6; mask_a = 7'b0;
    put(0, 5'd6, 32'h9999);
    step("R7 unused", 0, 1, 0, 0);

    // R10 tag 0 interlocks
    @(negedge clk); clear(); issue = 1; use_v = 2'b01; tag_a = 5'd0; mask_a = 7'b0;
    put(0, 5'd0, 32'h8888);
    step("R10 tag0", 1, 0, 0, 0);

    // R11 no issue, no stall
    @(negedge clk); issue = 0;
    step("R11 idle", 0, 0, 0, 0);

    // full sweep
    for (int p = 0; p < 3; p++)
      for (int d0 = 0; d0 < 3; d0++)
        for (int o = 0; o < 2; o++)
          for (int m = 0; m < 128; m++)
            run_seq(p, d0, o, 7'(m));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule